// File: doc/BRIEF.md
# Delta-Sigma Converter Sequencer over SPI

This block is the SPI master for a small four-input 12-bit delta-sigma converter. The converter is steered by a 16-bit control word and returns signed, left-justified results. A host pulses a request that carries an input-select code, a gain code, a rate code, a mode flag (single-shot or continuous) and a temperature-sensor flag. The sequencer builds the control word and runs the serial frames. It delivers each result sign-extended to 16 bits with a one-cycle valid strobe.

In single-shot mode the block sends the control word and releases chip select. It waits one worst-case conversion time at the fastest rate, then clocks in the result. In continuous mode it sends the control word plus a zero word and keeps chip select low. Before each read it waits on the converter's data-ready low level. That signal arrives on the serial data-in line, so it is visible only while chip select is low. A stop request ends continuous operation by sending a single-shot control word.

Top module: `dsadc_seq`

## Requirements
- R1: A single-shot control word has bit 15 = 1, bits 14:12 = input select, bits 11:9 = gain, bit 8 = 1, bits 7:5 = 110 (fastest rate, whatever rate was requested), bit 4 = temperature flag and bits 3:0 = 1010.
- R2: A gain code of 6 or 7 is sent as 2, and a rate code of 7 is sent as 4.
- R3: In single-shot mode, chip select is high between the control frame and the read frame. It stays high for at least ceil(CLK_HZ * ceil(1e6 / (3300 - ceil(3300/10))) / 1e6) clock cycles (337 us), and for no more than two cycles beyond that.
- R4: The result is bits 15:4 of the read word, sign-extended to 16 bits on sample_o. It comes with a valid_o pulse of exactly one cycle.
- R5: The serial clock idles low and toggles only while chip select is low. Each frame is 16 bits, MSB first. The sequencer drives data-out on the rising edge and samples data-in on the falling edge.
- R6: busy_o rises when a request is accepted. In single-shot mode it is still high in the valid_o cycle and low in the next cycle. A request made while busy_o is high is ignored.
- R7: Continuous start sends a control word with bit 15 = 0, bit 8 = 0 and bits 7:5 = the requested rate. A 16-bit zero word follows, and chip select stays low across both frames.
- R8: In continuous mode a read starts only after the data-in line, passed through two flops, has been seen high and then low while waiting. Chip select stays low between reads.
- R9: stop_i during continuous mode takes effect once any read in progress has finished. The sequencer raises chip select, then sends 0x010A followed by a zero word, and then drops busy_o.
- R10: After reset, chip select is high, the serial clock is low, and busy_o and valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, sampled when not busy |
| cont_i | input | 1 | 1 = continuous, 0 = single-shot |
| mux_i | input | 3 | Input-select code |
| gain_i | input | 3 | Gain code |
| rate_i | input | 3 | Rate code (continuous mode) |
| temp_i | input | 1 | Temperature-sensor select |
| stop_i | input | 1 | Ends continuous mode |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in, doubling as data-ready |
| busy_o | output | 1 | Sequence in progress |
| sample_o | output | 16 | Sign-extended result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a data-in line that is already low when continuous waiting begins. That happens after the zero word, and again after a read whose last bit was 0. A naive level detector would start a new read at once. The bench holds the line low after the start frames and checks that no serial clock appears. It then raises the line and lowers it again before a read is allowed. It also switches the line from the data-ready level to the slave's shift data at the first rising serial clock, so the read frame carries a known word.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 3;
  localparam int RES_W    = 12;
  localparam int RATE_TOP = 6;
  localparam int GAIN_TOP = 5;
  localparam int GAIN_DEF = 2;
  localparam int RATE_DEF = 4;
  localparam logic [WORD_W-1:0] STOP_WORD = 16'h010A;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SS_WR, ST_SS_GAP, ST_SS_RD, ST_DONE,
    ST_C_CFG, ST_C_ZERO, ST_C_WAIT, ST_C_RD,
    ST_P_GAP, ST_P_CFG, ST_P_ZERO
  } seq_state_e;

  function automatic int rate_hz(int code);
    case (code)
      0: return 128;
      1: return 250;
      2: return 490;
      3: return 920;
      4: return 1600;
      5: return 2400;
      default: return 3300;
    endcase
  endfunction

  // worst-case conversion time in clock cycles (nominal rate less 10%)
  function automatic int conv_wait(longint clk_hz, int code);
    longint hz, us;
    hz = longint'(rate_hz(code));
    hz = hz - (hz + 9) / 10;
    us = (64'd1_000_000 + hz - 1) / hz;
    return int'((us * clk_hz + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic logic [WORD_W-1:0] build_cfg(logic single, logic [CODE_W-1:0] mux,
                                                  logic [CODE_W-1:0] gain,
                                                  logic [CODE_W-1:0] rate, logic temp);
    logic [CODE_W-1:0] g, r;
    g = (gain > CODE_W'(GAIN_TOP)) ? CODE_W'(GAIN_DEF) : gain;
    r = single ? CODE_W'(RATE_TOP) : ((rate > CODE_W'(RATE_TOP)) ? CODE_W'(RATE_DEF) : rate);
    return {single, mux, g, single, r, temp, 4'b1010};
  endfunction
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= 2'b11;
    else         s_q <= {s_q[0], d_i};
  end

  assign q_o = s_q[1];
endmodule

// File: rtl/dsadc_spi_shift.sv
module dsadc_spi_shift #(
  parameter int DIV = 4,
  parameter int W   = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic         done_o
);
  localparam int HP_W  = $clog2(2 * W + 1);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0]     sh_q, rx_q;
  logic [HP_W-1:0]  hp_q;
  logic [DIV_W-1:0] div_q;
  logic             active_q, sclk_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; rx_q <= '0; hp_q <= '0; div_q <= '0;
      active_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        sh_q     <= tx_i;
        hp_q     <= '0;
        div_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DIV_W'(DIV - 1)) begin
          div_q <= '0;
          if (hp_q == HP_W'(2 * W)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            if (!hp_q[0]) begin
              sclk_q <= 1'b1;
              if (hp_q != '0) sh_q <= {sh_q[W-2:0], 1'b0};
            end else begin
              sclk_q <= 1'b0;
              rx_q   <= {rx_q[W-2:0], miso_i};
            end
            hp_q <= hp_q + 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = active_q & sh_q[W-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  a_r5_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_q);
  a_r5_done_ends_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter longint CLK_HZ = 50_000_000,
  parameter int     DIV    = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        cont_i,
  input  logic [2:0]  mux_i,
  input  logic [2:0]  gain_i,
  input  logic [2:0]  rate_i,
  input  logic        temp_i,
  input  logic        stop_i,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        busy_o,
  output logic [15:0] sample_o,
  output logic        valid_o
);
  import dsadc_pkg::*;

  localparam int SS_WAIT = conv_wait(CLK_HZ, RATE_TOP);
  localparam int CNT_W   = $clog2(SS_WAIT + DIV + 2);
  localparam int SHIFT   = WORD_W - RES_W;

  seq_state_e         state_q;
  logic [WORD_W-1:0]  cfg_q, tx_q, rx_w, sample_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               go_q, armed_q, stop_q, valid_q, done_w, rdy_w;

  dsadc_spi_shift #(.DIV(DIV), .W(WORD_W)) i_shift (
    .clk_i, .rst_ni, .start_i(go_q), .tx_i(tx_q), .miso_i,
    .sclk_o, .mosi_o, .rx_o(rx_w), .done_o(done_w)
  );

  dsadc_sync i_sync (.clk_i, .rst_ni, .d_i(miso_i), .q_o(rdy_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cfg_q <= '0; tx_q <= '0; cnt_q <= '0; sample_q <= '0;
      go_q <= 1'b0; armed_q <= 1'b0; stop_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      go_q    <= 1'b0;
      valid_q <= 1'b0;
      if (stop_i && state_q inside {ST_C_CFG, ST_C_ZERO, ST_C_WAIT, ST_C_RD}) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (req_i) begin
            cfg_q   <= build_cfg(!cont_i, mux_i, gain_i, rate_i, temp_i);
            tx_q    <= build_cfg(!cont_i, mux_i, gain_i, rate_i, temp_i);
            go_q    <= 1'b1;
            state_q <= cont_i ? ST_C_CFG : ST_SS_WR;
          end
        end
        ST_SS_WR: if (done_w) begin cnt_q <= '0; state_q <= ST_SS_GAP; end
        ST_SS_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(SS_WAIT - 1)) begin
            tx_q <= '0; go_q <= 1'b1; state_q <= ST_SS_RD;
          end
        end
        ST_SS_RD: if (done_w) begin
          sample_q <= WORD_W'($signed(rx_w) >>> SHIFT);
          valid_q  <= 1'b1;
          state_q  <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_C_CFG: if (done_w) begin tx_q <= '0; go_q <= 1'b1; state_q <= ST_C_ZERO; end
        ST_C_ZERO: if (done_w) begin armed_q <= 1'b0; state_q <= ST_C_WAIT; end
        ST_C_WAIT: begin
          if (stop_q) begin
            cnt_q <= '0; state_q <= ST_P_GAP;
          end else if (armed_q && !rdy_w) begin
            tx_q <= '0; go_q <= 1'b1; state_q <= ST_C_RD;
          end else if (rdy_w) begin
            armed_q <= 1'b1;
          end
        end
        ST_C_RD: if (done_w) begin
          sample_q <= WORD_W'($signed(rx_w) >>> SHIFT);
          valid_q  <= 1'b1;
          armed_q  <= 1'b0;
          state_q  <= ST_C_WAIT;
        end
        ST_P_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DIV - 1)) begin
            tx_q <= STOP_WORD; go_q <= 1'b1; state_q <= ST_P_CFG;
          end
        end
        ST_P_CFG: if (done_w) begin tx_q <= '0; go_q <= 1'b1; state_q <= ST_P_ZERO; end
        ST_P_ZERO: if (done_w) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no    = state_q inside {ST_IDLE, ST_SS_GAP, ST_DONE, ST_P_GAP};
  assign busy_o   = (state_q != ST_IDLE);
  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  a_r5_sclk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  a_r4_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r4_sign_extended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(sample_o[15:11]) == 0 || $countones(sample_o[15:11]) == 5));
  a_r6_busy_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o);
  a_r6_busy_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> $stable(cfg_q));
  a_r8_no_read_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C_WAIT && !armed_q && !stop_q) |=> state_q != ST_C_RD);
endmodule

// File: tb/test_dsadc_seq.sv
module test_dsadc_seq;
  localparam longint CLK_HZ = 1_000_000;
  localparam int     DIV    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, cont = 1'b0, temp = 1'b0, stop = 1'b0;
  logic [2:0] mux = '0, gain = '0, rate = '0;
  logic sclk, cs_n, mosi, miso, busy, valid;
  logic [15:0] sample;

  logic [15:0] slave_word = 16'h0000;
  logic        slave_bit = 1'b1, drdy_mode = 1'b0, drdy_lvl = 1'b1;
  logic [15:0] cap_sh = '0;
  int          cap_bits = 0, nf = 0;
  logic [15:0] frames [64];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  assign miso = cs_n ? 1'b1 : (drdy_mode ? drdy_lvl : slave_bit);

  dsadc_seq #(.CLK_HZ(CLK_HZ), .DIV(DIV)) i_dsadc_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cont_i(cont), .mux_i(mux),
    .gain_i(gain), .rate_i(rate), .temp_i(temp), .stop_i(stop),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .sample_o(sample), .valid_o(valid)
  );

  always @(posedge sclk) slave_bit <= slave_word[15 - cap_bits];

  always @(negedge sclk) begin
    cap_sh = {cap_sh[14:0], mosi};
    cap_bits = cap_bits + 1;
    if (cap_bits == 16) begin
      if (nf < 64) frames[nf] = cap_sh;
      nf = nf + 1;
      cap_bits = 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (valid) return;
    end
  endtask

  // expected wait from R3: 3300 - 330 = 2970 sps -> 337 us
  localparam int EXP_WAIT = int'((337 * CLK_HZ + 999_999) / 1_000_000);

  task automatic run_ss(logic [2:0] m, logic [2:0] g, logic [2:0] r, logic t,
                        logic [15:0] word, bit inject, output int gap, output int start);
    slave_word = word;
    start = nf;
    gap = 0;
    @(negedge clk);
    mux = m; gain = g; rate = r; temp = t; cont = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (inject && i == 10) begin
        mux = 3'd6; gain = 3'd1; temp = 1'b0; req = 1'b1;
      end else req = 1'b0;
      if (nf == start + 1 && cs_n) gap++;
      if (valid) break;
    end
  endtask

  // {mux, gain, temp, rate, slave word, expected cfg, expected sample}
  localparam logic [57:0] VEC [5] = '{
    {3'd0, 3'd2, 1'b0, 3'd1, 16'h7FF0, 16'h85CA, 16'h07FF},
    {3'd5, 3'd0, 1'b0, 3'd3, 16'h8000, 16'hD1CA, 16'hF800},
    {3'd7, 3'd5, 1'b0, 3'd7, 16'hFFFF, 16'hFBCA, 16'hFFFF},
    {3'd3, 3'd7, 1'b1, 3'd0, 16'h123F, 16'hB5DA, 16'h0123},
    {3'd2, 3'd3, 1'b0, 3'd6, 16'h800F, 16'hA7CA, 16'hF800}
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int gap, st, f0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cs_n", 32'(cs_n), 32'd1);
    check("R10 sclk", 32'(sclk), 32'd0);
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 valid", 32'(valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 sclk idle low", 32'(sclk), 32'd0);

    // R1 R2 R3 R4: single-shot vectors
    for (int v = 0; v < 5; v++) begin
      run_ss(VEC[v][57:55], VEC[v][54:52], VEC[v][50:48], VEC[v][51], VEC[v][47:32], 1'b0, gap, st);
      check($sformatf("R4 valid v%0d", v), 32'(valid), 32'd1);
      check($sformatf("R6 busy at valid v%0d", v), 32'(busy), 32'd1);
      check($sformatf("R4 sample v%0d", v), 32'(sample), 32'(VEC[v][15:0]));
      check($sformatf("R1 R2 cfg v%0d", v), 32'(frames[st]), 32'(VEC[v][31:16]));
      check($sformatf("R5 read frame mosi v%0d", v), 32'(frames[st + 1]), 32'd0);
      check($sformatf("R3 gap v%0d", v), 32'(gap >= EXP_WAIT && gap <= EXP_WAIT + 2), 32'd1);
      @(negedge clk);
      check($sformatf("R4 valid drops v%0d", v), 32'(valid), 32'd0);
      check($sformatf("R6 busy drops v%0d", v), 32'(busy), 32'd0);
    end

    // R6: request during busy is ignored
    run_ss(3'd1, 3'd4, 3'd0, 1'b0, 16'h0450, 1'b1, gap, st);
    check("R6 ignored sample", 32'(sample), 32'h0045);
    check("R6 ignored cfg", 32'(frames[st]), 32'h99CA);
    repeat (200) @(negedge clk);
    check("R6 no extra frames", 32'(nf), 32'(st + 2));
    check("R6 idle after ignore", 32'(busy), 32'd0);

    // continuous: R7 R8 R9
    drdy_mode = 1'b1; drdy_lvl = 1'b0;
    f0 = nf;
    @(negedge clk);
    mux = 3'd4; gain = 3'd1; rate = 3'd7; temp = 1'b0; cont = 1'b1; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 2000 && nf < f0 + 2; i++) @(negedge clk);
    check("R7 R2 cont cfg", 32'(frames[f0]), 32'h428A);
    check("R7 zero word", 32'(frames[f0 + 1]), 32'h0000);
    check("R7 cs low", 32'(cs_n), 32'd0);
    repeat (60) @(negedge clk);
    check("R8 no read while line only low", 32'(nf), 32'(f0 + 2));
    check("R8 sclk quiet", 32'(sclk), 32'd0);
    drdy_lvl = 1'b1;
    repeat (5) @(negedge clk);
    slave_word = 16'h4560;
    drdy_lvl = 1'b0;
    @(posedge sclk);
    drdy_mode = 1'b0;
    wait_valid();
    check("R8 first sample", 32'(sample), 32'h0456);
    drdy_mode = 1'b1; drdy_lvl = 1'b1;
    @(negedge clk);
    check("R8 cs held low", 32'(cs_n), 32'd0);
    check("R8 busy held", 32'(busy), 32'd1);
    repeat (5) @(negedge clk);
    slave_word = 16'hA5A0;
    drdy_lvl = 1'b0;
    @(posedge sclk);
    drdy_mode = 1'b0;
    wait_valid();
    check("R8 second sample", 32'(sample), 32'hFA5A);
    drdy_mode = 1'b1; drdy_lvl = 1'b1;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check("R9 frame count", 32'(nf), 32'(f0 + 6));
    check("R9 stop cfg", 32'(frames[f0 + 4]), 32'h010A);
    check("R9 trailing zero", 32'(frames[f0 + 5]), 32'h0000);
    check("R9 busy low", 32'(busy), 32'd0);
    check("R9 cs high", 32'(cs_n), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule